// File: doc/BRIEF.md
# Redundant Settings Record Selector

The block sits on the read side of a byte-wide configuration memory and recovers the user-settings record that is stored there twice. A start pulse begins the search. The block first reads a 16-bit pointer word, which places both copies in memory. It then scans each copy, recomputes that copy's CRC-16 and compares it with the checksum held in the copy's trailer. If both copies pass, it keeps the copy with the larger write count. Finally it streams the payload of the chosen copy out over a valid/ready byte interface.

The memory port is a bare address bus with a fixed one-cycle read latency. The address driven in one cycle is answered on `mem_rdata_i` in the next cycle. Payload bytes leave through a single output register. `out_valid_o` stays high and `out_data_o` stays stable until `out_ready_i` is sampled high at a clock edge. Holding `out_ready_i` low stalls the memory reads, and no byte is lost or repeated. `done_o` marks the end of every search. `good_o` tells whether a record was delivered.

Top module: `cfg_record_select`

## Requirements
- R1: The record area base is the little-endian word at byte addresses 0x20 (low byte) and 0x21 (high byte), shifted left by 3. Copy A starts at that base and copy B starts at base + 0x100.
- R2: If the base is greater than 0x3FE00, the search fails: `done_o` pulses, `good_o` stays low and no payload byte is offered. A base equal to 0x3FE00 is still searched.
- R3: A copy is valid only if a CRC-16 matches the little-endian word at copy offsets 0x72 (low) and 0x73 (high). The CRC is reflected, with polynomial 0xA001, start value 0xFFFF, LSB first, and runs over the copy's bytes 0x00..0x6F.
- R4: When both copies are valid, copy B is chosen only if its write count (little-endian, offsets 0x70 low and 0x71 high, compared unsigned) is strictly greater than copy A's. Otherwise copy A is chosen.
- R5: When exactly one copy is valid, that copy is chosen.
- R6: When neither copy is valid, `done_o` pulses, `good_o` stays low and no payload byte is offered.
- R7: On success, exactly 0x70 bytes are delivered: offsets 0x00..0x6F of the chosen copy, in ascending order.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` does not change on the next cycle.
- R9: `done_o` is high for exactly one cycle. On success this is the cycle after the edge that accepts the last payload byte. `good_o` becomes valid with `done_o` and holds its value until the next accepted start.
- R10: `start_i` is ignored from the cycle a start is accepted through the `done_o` cycle, inclusive.
- R11: After reset, `done_o`, `good_o` and `out_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| mem_addr_o | output | ADDR_W (18) | Byte read address |
| mem_rdata_i | input | 8 | Read data for the address driven one cycle earlier |
| out_valid_o | output | 1 | Payload byte available |
| out_ready_i | input | 1 | Sink accepts the payload byte at this edge |
| out_data_o | output | 8 | Payload byte |
| done_o | output | 1 | One-cycle end-of-search pulse |
| good_o | output | 1 | A record was delivered by the last search |

## Verification
A wrong pointer or a wrong copy offset makes the payload stream differ from the first byte onward. A wrong CRC step or a wrong trailer decode shows up as a wrong copy choice or a wrong `good_o`, but only once `done_o` appears, about 250 cycles after start. A slip in the read-latency alignment shifts every byte by one position, so the first compared byte already exposes it. Back-pressure faults show as a changed byte during a stall, or as a count other than 0x70. A start that is not ignored while busy shows up as a second `done_o` or as unexpected bytes after the run has finished.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PTR,
    ST_CHECK,
    ST_SCAN,
    ST_PICK,
    ST_STREAM,
    ST_FIN
  } rsel_state_t;
endpackage

// File: rtl/rsel_crc_step.sv
module rsel_crc_step #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY  = 16'hA001
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [7:0]       din,
  output logic [CRC_W-1:0] crc_out
);
  logic [CRC_W-1:0] chain [0:8];

  assign chain[0] = crc_in ^ CRC_W'(din);

  // one reflected shift per data bit, LSB first
  for (genvar g = 0; g < 8; g++) begin : g_bit
    assign chain[g+1] = chain[g][0] ? ((chain[g] >> 1) ^ POLY[CRC_W-1:0])
                                    : (chain[g] >> 1);
  end

  assign crc_out = chain[8];
endmodule

// File: rtl/rsel_pick.sv
module rsel_pick #(
  parameter int CNT_W = 16
) (
  input  logic             ok_a,
  input  logic             ok_b,
  input  logic [CNT_W-1:0] cnt_a,
  input  logic [CNT_W-1:0] cnt_b,
  output logic             take_b,
  output logic             any_ok
);
  always_comb begin
    any_ok = ok_a | ok_b;
    if (ok_a && ok_b) take_b = (cnt_b > cnt_a);
    else              take_b = ok_b;
  end
endmodule

// File: rtl/rsel_outbuf.sv
module rsel_outbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       ready,
  output logic       valid,
  output logic [7:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R8
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data));

  // R8
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!valid || ready));
endmodule

// File: rtl/cfg_record_select.sv
module cfg_record_select
  import rsel_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int PTR_ADDR    = 'h20,
  parameter int BASE_SHIFT  = 3,
  parameter int BASE_LIMIT  = 'h3FE00,
  parameter int COPY_STRIDE = 'h100,
  parameter int PAYLOAD_LEN = 'h70,
  parameter logic [15:0] CRC_POLY = 16'hA001,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [7:0]        out_data_o,
  output logic              done_o,
  output logic              good_o
);
  localparam int REC_LEN = PAYLOAD_LEN + 4;
  localparam int IDX_W   = $clog2(REC_LEN + 1);
  localparam int BASE_W  = 16 + BASE_SHIFT;
  localparam logic [BASE_W-1:0] LIMIT_W = BASE_W'(BASE_LIMIT);
  localparam logic [IDX_W-1:0]  IDX_PL  = IDX_W'(PAYLOAD_LEN);
  localparam logic [IDX_W-1:0]  IDX_LST = IDX_W'(REC_LEN - 1);

  rsel_state_t       state;
  logic [IDX_W-1:0]  iss_cnt, rd_idx;
  logic              iss_cp, iss_stop, iss_on;
  logic              rd_vld, rd_cp;
  logic [15:0]       ptr_q;
  logic [15:0]       crc_q, crc_in, crc_nx;
  logic [7:0]        cnt_lo, sum_lo;
  logic [15:0]       cnt_a, cnt_b;
  logic              ok_a, ok_b, take_b, any_ok;
  logic [ADDR_W-1:0] sel_base;
  logic [IDX_W-1:0]  acc_cnt;
  logic              good_q;
  logic [BASE_W-1:0] base_w;
  logic [ADDR_W-1:0] scan_base;
  logic              stream_load;

  assign base_w    = {ptr_q, {BASE_SHIFT{1'b0}}};
  assign scan_base = base_w[ADDR_W-1:0];
  assign crc_in    = (rd_idx == '0) ? CRC_INIT : crc_q;

  rsel_crc_step #(.CRC_W(16), .POLY(CRC_POLY)) i_crc (
    .crc_in (crc_in),
    .din    (mem_rdata_i),
    .crc_out(crc_nx)
  );

  rsel_pick #(.CNT_W(16)) i_pick (
    .ok_a  (ok_a),
    .ok_b  (ok_b),
    .cnt_a (cnt_a),
    .cnt_b (cnt_b),
    .take_b(take_b),
    .any_ok(any_ok)
  );

  assign stream_load = rd_vld && (state == ST_STREAM);

  rsel_outbuf i_obuf (
    .clk  (clk),
    .rst_n(rst_n),
    .load (stream_load),
    .din  (mem_rdata_i),
    .ready(out_ready_i),
    .valid(out_valid_o),
    .data (out_data_o)
  );

  // read issue: one address per cycle, answered one cycle later
  always_comb begin
    iss_on     = 1'b0;
    mem_addr_o = '0;
    unique case (state)
      ST_PTR: begin
        iss_on     = (iss_cnt < IDX_W'(2));
        mem_addr_o = ADDR_W'(PTR_ADDR) + ADDR_W'(iss_cnt);
      end
      ST_SCAN: begin
        iss_on     = !iss_stop;
        mem_addr_o = scan_base + (iss_cp ? ADDR_W'(COPY_STRIDE) : '0)
                   + ADDR_W'(iss_cnt);
      end
      ST_STREAM: begin
        iss_on     = (iss_cnt < IDX_PL) && !rd_vld
                   && (!out_valid_o || out_ready_i);
        mem_addr_o = sel_base + ADDR_W'(iss_cnt);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      iss_cnt  <= '0;
      iss_cp   <= 1'b0;
      iss_stop <= 1'b0;
      rd_vld   <= 1'b0;
      rd_idx   <= '0;
      rd_cp    <= 1'b0;
      ptr_q    <= '0;
      crc_q    <= '0;
      cnt_lo   <= '0;
      sum_lo   <= '0;
      cnt_a    <= '0;
      cnt_b    <= '0;
      ok_a     <= 1'b0;
      ok_b     <= 1'b0;
      sel_base <= '0;
      acc_cnt  <= '0;
      good_q   <= 1'b0;
    end else begin
      rd_vld <= iss_on;
      rd_idx <= iss_cnt;
      rd_cp  <= iss_cp;
      if (iss_on) begin
        if (state == ST_SCAN && iss_cnt == IDX_LST) begin
          iss_cnt <= '0;
          if (iss_cp) iss_stop <= 1'b1;
          else        iss_cp   <= 1'b1;
        end else begin
          iss_cnt <= iss_cnt + 1'b1;
        end
      end

      unique case (state)
        ST_IDLE: begin
          if (start_i) begin
            state    <= ST_PTR;
            good_q   <= 1'b0;
            iss_cnt  <= '0;
            iss_cp   <= 1'b0;
            iss_stop <= 1'b0;
            acc_cnt  <= '0;
          end
        end
        ST_PTR: begin
          if (rd_vld) begin
            if (rd_idx == '0) begin
              ptr_q[7:0] <= mem_rdata_i;
            end else begin
              ptr_q[15:8] <= mem_rdata_i;
              state       <= ST_CHECK;
              iss_cnt     <= '0;
            end
          end
        end
        ST_CHECK: begin
          if (base_w > LIMIT_W) state <= ST_FIN;
          else                  state <= ST_SCAN;
        end
        ST_SCAN: begin
          if (rd_vld) begin
            if (rd_idx < IDX_PL) begin
              crc_q <= crc_nx;
            end else if (rd_idx == IDX_PL) begin
              cnt_lo <= mem_rdata_i;
            end else if (rd_idx == IDX_PL + 1'b1) begin
              if (rd_cp) cnt_b <= {mem_rdata_i, cnt_lo};
              else       cnt_a <= {mem_rdata_i, cnt_lo};
            end else if (rd_idx == IDX_PL + 2'd2) begin
              sum_lo <= mem_rdata_i;
            end else begin
              if (rd_cp) begin
                ok_b  <= (crc_q == {mem_rdata_i, sum_lo});
                state <= ST_PICK;
              end else begin
                ok_a  <= (crc_q == {mem_rdata_i, sum_lo});
              end
            end
          end
        end
        ST_PICK: begin
          if (any_ok) begin
            sel_base <= scan_base + (take_b ? ADDR_W'(COPY_STRIDE) : '0);
            iss_cnt  <= '0;
            state    <= ST_STREAM;
          end else begin
            state <= ST_FIN;
          end
        end
        ST_STREAM: begin
          if (out_valid_o && out_ready_i) begin
            acc_cnt <= acc_cnt + 1'b1;
            if (acc_cnt == IDX_PL - 1'b1) begin
              state  <= ST_FIN;
              good_q <= 1'b1;
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done_o = (state == ST_FIN);
  assign good_o = good_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  good_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good_o) |-> done_o);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) && start_i |=> (state != ST_PTR) || ($past(state) == ST_PTR));

  // R7
  stream_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (state == ST_STREAM));
endmodule

// File: tb/test_cfg_record_select.sv
module test_cfg_record_select;
  localparam int AW  = 18;
  localparam int PL  = 'h70;
  localparam int LIM = 'h3FE00;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          out_ready = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = 8'h00;
  logic [7:0]    out_data;
  logic          out_valid, done, good;

  always #10 clk = ~clk;

  cfg_record_select i_cfg_record_select (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .done_o(done), .good_o(good)
  );

  logic [7:0] mem [int];
  logic [7:0] exp_pay [PL];
  bit         exp_good;
  int         n_chk = 0, n_bad = 0;

  function automatic logic [7:0] rdm(int a);
    if (mem.exists(a)) return mem[a];
    return 8'((a * 37) ^ (a >> 5) ^ 8'h5A);
  endfunction

  always @(posedge clk) mem_rdata <= rdm(int'(mem_addr));

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_of(int a, int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, rdm(a + i)};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [15:0] word_at(int a);
    return {rdm(a + 1), rdm(a)};
  endfunction

  function automatic void predict();
    int base, pick;
    bit ok0, ok1;
    base = int'(word_at('h20)) << 3;
    exp_good = 1'b0;
    if (base > LIM) return;
    ok0 = crc_of(base, PL) == word_at(base + 'h72);
    ok1 = crc_of(base + 'h100, PL) == word_at(base + 'h100 + 'h72);
    if (!ok0 && !ok1) return;
    if (ok0 && ok1) pick = (word_at(base + 'h170) > word_at(base + 'h70)) ? 1 : 0;
    else            pick = ok1 ? 1 : 0;
    exp_good = 1'b1;
    for (int i = 0; i < PL; i++) exp_pay[i] = rdm(base + pick * 'h100 + i);
  endfunction

  task automatic build(int ptr, bit v0, bit v1, int c0, int c1);
    int base;
    mem.delete();
    mem['h20] = 8'(ptr);
    mem['h21] = 8'(ptr >> 8);
    base = ptr << 3;
    if (base > LIM) return;
    for (int k = 0; k < 2; k++) begin
      int b = base + k * 'h100;
      logic [15:0] c, cnt;
      for (int i = 0; i < PL; i++) mem[b + i] = 8'($urandom);
      cnt = 16'((k == 0) ? c0 : c1);
      mem[b + 'h70] = cnt[7:0];
      mem[b + 'h71] = cnt[15:8];
      c = crc_of(b, PL);
      if (!((k == 0) ? v0 : v1)) c = c ^ 16'h8001;
      mem[b + 'h72] = c[7:0];
      mem[b + 'h73] = c[15:8];
    end
  endtask

  task automatic run(string req, bit poke, int rdy_pct);
    int got = 0, mism = 0, holdv = 0, cyc = 0, last_acc = -10, gap = 0;
    bit prev_stall = 0, seen = 0, extra = 0;
    logic [7:0] prev_data = 8'h00;
    predict();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!seen && cyc < 4000) begin
      if (prev_stall && !(out_valid && out_data == prev_data)) holdv++;
      if (done) begin
        seen = 1;
        gap = cyc - last_acc;
      end else begin
        out_ready = (($urandom % 100) < rdy_pct);
        start = poke && (got >= 10) && (got < 14);
        if (out_valid && out_ready) begin
          if (got < PL && out_data != exp_pay[got]) mism++;
          got++;
          last_acc = cyc;
        end
        prev_stall = out_valid && !out_ready;
        prev_data = out_data;
        @(negedge clk);
        cyc++;
      end
    end
    check(seen, req, "watchdog: done seen", int'(seen), 1);
    check(good == exp_good, req, "good flag at done", int'(good), int'(exp_good));
    check(got == (exp_good ? PL : 0), exp_good ? "R7" : req, "byte count", got, exp_good ? PL : 0);
    check(mism == 0, "R7", "payload byte mismatches", mism, 0);
    check(holdv == 0, "R8", "stall hold violations", holdv, 0);
    if (exp_good) check(gap == 1, "R9", "done delay after last byte", gap, 1);
    // R10: start also raised in the done cycle itself
    if (poke) start = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!done, "R9", "done width", int'(done), 0);
    for (int i = 0; i < (poke ? 600 : 4); i++) begin
      if (done || out_valid) extra = 1;
      @(negedge clk);
    end
    check(!extra, poke ? "R10" : "R9", "activity after done", int'(extra), 0);
    check(good == exp_good, "R9", "good held after done", int'(good), int'(exp_good));
    out_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!done && !good && !out_valid, "R11", "reset outputs",
          {done, good, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    build('h0200, 1, 1, 5, 9);       run("R4", 0, 100);
    build('h0300, 1, 1, 7, 7);       run("R4", 0, 70);
    build('h0400, 1, 1, 'hFFFF, 0);  run("R4", 0, 80);
    build('h0500, 0, 1, 9, 1);       run("R5", 0, 60);
    build('h0600, 1, 0, 1, 9);       run("R5", 0, 60);
    build('h0700, 0, 0, 1, 2);       run("R6", 0, 60);
    build('h0800, 0, 0, 3, 3);       run("R3", 0, 90);
    build('h7FC1, 1, 1, 1, 2);       run("R2", 0, 60);
    build('hFFFF, 1, 1, 1, 2);       run("R2", 0, 60);
    build('h7FC0, 1, 1, 4, 2);       run("R1", 0, 50);
    build('h0010, 1, 1, 0, 1);       run("R1", 0, 100);
    build('h0900, 1, 1, 2, 3);       run("R10", 1, 100);
    build('h0A00, 1, 1, 8, 3);       run("R8", 0, 25);

    for (int t = 0; t < 30; t++) begin
      int ptr = 'h10 + int'($urandom % ('h7FC0 - 'h10 + 1));
      int c0 = int'($urandom % 65536);
      int c1 = ($urandom % 4 == 0) ? c0 : int'($urandom % 65536);
      build(ptr, 1'($urandom), 1'($urandom), c0, c1);
      run("R4", 0, 30 + int'($urandom % 71));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule